// File: doc/BRIEF.md
# Pin Interrupt Status Unit with Separate Capture and Report Enables

This block gathers interrupt requests from a set of general-purpose input pins and presents them to the processor as one summary interrupt line. Every pin first passes through a synchroniser. A detector then evaluates the pin against its own trigger setting, which is one of four: active-high level, active-low level, rising edge or falling edge. When the detector fires, the result is held in a per-pin status bit.

Each pin has two independent enables. The capture enable decides whether a detected condition may set the status bit at all. The report enable decides only whether a status bit that is already set drives the summary line. Because the report enable never stops capture, an edge that arrives while a pin is masked is still recorded. A level source that is still active when software clears its bit is recorded again. Software reaches the block through a small port with valid, write, address and data signals. Through it software writes and reads the per-pin settings, reads the status bits and clears them by writing ones.

Top module: `gpio_irq_latch`

## Requirements
- R1: After reset all status bits, all pin settings, `irq_out` and `reg_rdata` are zero.
- R2: The setting register of pin i sits at address i. In it, bits [1:0] select the trigger: 00 level-high, 01 level-low, 10 rising edge, 11 falling edge. Bit 2 is the capture enable and bit 3 is the report enable. Higher bits read as zero. The status register sits at address NUM_PINS, with bit i belonging to pin i. Any other address reads zero. A read returns its data on `reg_rdata` in the cycle after the request.
- R3: While a pin's capture enable is clear, its status bit is never set, whatever the input does.
- R4: In level mode with capture enabled, an active input sets the status bit. The bit then stays set after the input goes inactive, until software clears it.
- R5: In level mode, clearing the status bit while the input is still active leaves the bit set.
- R6: In edge mode only a transition in the selected direction sets the status bit. A transition in the other direction, or an input that stays at its level, sets nothing. Edges are captured while the report enable is clear.
- R7: `irq_out` is registered. It is high exactly when, in the previous cycle, some pin had its status bit set and its report enable set.
- R8: Writing the status register clears the bits written as one and leaves the others unchanged. If a new event for a pin arrives in the same cycle as its clear, the bit stays set.
- R9: Changing a pin's setting while its input is steady creates no event.
- R10: An input change is resynchronised by two flops. An input that is stable before clock edge k raises `irq_out` at edge k+3 when both enables are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | NUM_PINS | Asynchronous pin inputs |
| reg_valid | input | 1 | Register access request this cycle |
| reg_write | input | 1 | 1 for write, 0 for read |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after a read request |
| irq_out | output | 1 | Summary interrupt to the processor |

## Verification
The bench clears a level-high pin while its input is still active. A design that let the clear win would read back zero at that point, and the source would then be lost. It records edges on a masked pin and checks that they become visible once the report enable is set. A design that gated capture with the report enable would never raise the line. It rewrites the settings of a pin whose input is held high and expects no event. A design that reset its edge history to zero would latch a false rising edge. It also checks the latency from an input change to the summary line. A missing or extra synchroniser stage would move the rising edge of `irq_out` by one cycle, and the bench would report it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   typedef enum logic [1:0] {
      TRIG_LVL_HI = 2'b00,
      TRIG_LVL_LO = 2'b01,
      TRIG_RISE   = 2'b10,
      TRIG_FALL   = 2'b11
   } trig_e;

   typedef struct packed {
      logic  rpt_en;
      logic  cap_en;
      trig_e trig;
   } pin_cfg_t;

   localparam int CFG_W = $bits(pin_cfg_t);

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= '0;
         end else if (s == 0) begin
            stage_q[s] <= d;
         end else begin
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
   import gpio_irq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     pin_s,
   input  pin_cfg_t cfg,
   output logic     evt
);

   logic hist_q;
   logic cond;

   // History runs in every mode, so a mode change always compares
   // against the true previous level.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= 1'b0;
      else        hist_q <= pin_s;
   end

   always_comb begin
      unique case (cfg.trig)
         TRIG_LVL_HI: cond = pin_s;
         TRIG_LVL_LO: cond = ~pin_s;
         TRIG_RISE:   cond = pin_s & ~hist_q;
         TRIG_FALL:   cond = ~pin_s & hist_q;
         default:     cond = 1'b0;
      endcase
   end

   assign evt = cfg.cap_en & cond;

endmodule

// File: rtl/gpio_summary.sv
module gpio_summary #(
   parameter int NUM_PINS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] status,
   input  logic [NUM_PINS-1:0] rpt_en,
   output logic                irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |(status & rpt_en);
   end

endmodule

// File: rtl/gpio_irq_latch.sv
module gpio_irq_latch
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS    = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int ADDR_W     = $clog2(NUM_PINS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] gpio_in,
   input  logic                reg_valid,
   input  logic                reg_write,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic                irq_out
);

   localparam int STATUS_ADDR = NUM_PINS;

   if (NUM_PINS < 1) begin : g_bad_pins
      $error("gpio_irq_latch: NUM_PINS must be at least 1");
   end
   if (DATA_W < NUM_PINS || DATA_W < CFG_W) begin : g_bad_width
      $error("gpio_irq_latch: DATA_W too narrow for status or settings");
   end

   pin_cfg_t [NUM_PINS-1:0] cfg_q;
   logic [NUM_PINS-1:0]     status_q;
   logic [NUM_PINS-1:0]     evt_vec;
   logic [NUM_PINS-1:0]     ack_vec;
   logic [NUM_PINS-1:0]     cap_en_vec;
   logic [NUM_PINS-1:0]     rpt_en_vec;
   logic [NUM_PINS-1:0]     pin_s;
   logic [DATA_W-1:0]       rd_mux;
   logic                    wr_req;
   logic                    rd_req;
   logic                    unused_wdata;

   assign wr_req       = reg_valid & reg_write;
   assign rd_req       = reg_valid & ~reg_write;
   assign unused_wdata = ^reg_wdata;

   gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (gpio_in),
      .q     (pin_s)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q[i] <= '0;
         end else if (wr_req && reg_addr == ADDR_W'(i)) begin
            cfg_q[i] <= pin_cfg_t'(reg_wdata[CFG_W-1:0]);
         end
      end

      gpio_pin_detect u_det (
         .clk   (clk),
         .rst_n (rst_n),
         .pin_s (pin_s[i]),
         .cfg   (cfg_q[i]),
         .evt   (evt_vec[i])
      );

      assign cap_en_vec[i] = cfg_q[i].cap_en;
      assign rpt_en_vec[i] = cfg_q[i].rpt_en;
   end

   assign ack_vec = (wr_req && reg_addr == ADDR_W'(STATUS_ADDR))
                    ? reg_wdata[NUM_PINS-1:0] : '0;

   // New events override a clear in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (status_q & ~ack_vec) | evt_vec;
   end

   gpio_summary #(.NUM_PINS(NUM_PINS)) u_sum (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (status_q),
      .rpt_en (rpt_en_vec),
      .irq    (irq_out)
   );

   always_comb begin
      rd_mux = '0;
      if (reg_addr == ADDR_W'(STATUS_ADDR)) begin
         rd_mux[NUM_PINS-1:0] = status_q;
      end
      for (int i = 0; i < NUM_PINS; i++) begin
         if (reg_addr == ADDR_W'(i)) rd_mux[CFG_W-1:0] = cfg_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (rd_req) reg_rdata <= rd_mux;
   end

endmodule

// File: rtl/gpio_irq_latch_chk.sv
module gpio_irq_latch_chk #(
   parameter int NUM_PINS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                irq_out,
   input logic [NUM_PINS-1:0] status,
   input logic [NUM_PINS-1:0] cap_vec,
   input logic [NUM_PINS-1:0] rpt_vec,
   input logic [NUM_PINS-1:0] ack_vec,
   input logic [NUM_PINS-1:0] evt_vec
);

   // R7
   summary_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == |($past(status) & $past(rpt_vec)));

   // R3
   no_capture_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~$past(status) & ~$past(cap_vec)) == '0);

   // R4
   pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status) & ~$past(ack_vec) & ~status) == '0);

   // R8
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ack_vec) & ~$past(evt_vec) & status) == '0);

   // R8
   event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(evt_vec) & ~status) == '0);

endmodule

bind gpio_irq_latch gpio_irq_latch_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq_out (irq_out),
   .status  (status_q),
   .cap_vec (cap_en_vec),
   .rpt_vec (rpt_en_vec),
   .ack_vec (ack_vec),
   .evt_vec (evt_vec)
);

// File: tb/gpio_irq_latch_test.sv
module gpio_irq_latch_test;

   localparam int CLK_PERIOD = 10;
   localparam int N  = 8;
   localparam int DW = 8;
   localparam int AW = $clog2(N + 1);
   localparam logic [AW-1:0] ST_ADDR = AW'(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  gpio_in = '0;
   logic          reg_valid = 1'b0;
   logic          reg_write = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          irq_out;

   int n_checks = 0;
   int n_fail   = 0;

   typedef struct {
      logic [DW-1:0] exp;
      string         name;
   } exp_t;
   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_irq_latch #(.NUM_PINS(N), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in),
      .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
   );

   task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                        input string name);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", name, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0;
   endtask

   // Driver: pushes the expected read value and issues the read.
   task automatic reg_rd(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                         input string name);
      exp_t it;
      it.exp = exp; it.name = name;
      @(negedge clk);
      sb_q.push_back(it);
      reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
      @(negedge clk);
      reg_valid = 1'b0;
   endtask

   task automatic check_irq(input logic exp, input string name);
      check(DW'(irq_out), DW'(exp), name);
   endtask

   // Monitor: compares read data a quarter period after the capturing edge.
   initial begin
      exp_t item;
      forever begin
         @(posedge clk);
         if (reg_valid && !reg_write) begin
            #(CLK_PERIOD/4);
            item = sb_q.pop_front();
            check(reg_rdata, item.exp, item.name);
         end
      end
   end

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_fail++;
      $display("FAIL watchdog expired (all requirements)");
      finish_run();
   end

   initial begin
      idle(3);
      check(reg_rdata, '0, "R1 rdata after reset");
      check_irq(1'b0, "R1 irq after reset");
      rst_n = 1'b1;
      reg_rd(ST_ADDR, 8'h00, "R1 status after reset");
      reg_rd(AW'(3), 8'h00, "R1 setting after reset");

      // R2 setting layout: high bits dropped, unused address reads zero
      reg_wr(AW'(5), 8'hF2);
      reg_rd(AW'(5), 8'h02, "R2 setting readback");
      reg_rd(AW'(N + 1), 8'h00, "R2 unused address");
      reg_wr(AW'(5), 8'h00);

      // R10 latency, R4 level capture, R7 summary: pin0 level-high, both enables
      reg_wr(AW'(0), 8'h0C);
      gpio_in[0] = 1'b1;
      idle(3);
      check_irq(1'b0, "R10 irq not before third edge");
      idle(1);
      check_irq(1'b1, "R10 irq at third edge");
      gpio_in[0] = 1'b0;
      idle(4);
      reg_rd(ST_ADDR, 8'h01, "R4 level stays pending after release");
      check_irq(1'b1, "R7 irq while pending");
      reg_wr(ST_ADDR, 8'h01);
      idle(1);
      check_irq(1'b0, "R7 irq drops after clear");
      reg_rd(ST_ADDR, 8'h00, "R8 clear of released level");

      // R5 clear while level still active
      gpio_in[0] = 1'b1;
      idle(4);
      reg_wr(ST_ADDR, 8'h01);
      idle(2);
      reg_rd(ST_ADDR, 8'h01, "R5 level recaptured after clear");
      check_irq(1'b1, "R5 irq stays high");
      gpio_in[0] = 1'b0;
      idle(4);
      reg_wr(ST_ADDR, 8'h01);
      idle(2);
      reg_rd(ST_ADDR, 8'h00, "R5 clear after release");

      // R3 capture disabled
      reg_wr(AW'(1), 8'h08);
      gpio_in[1] = 1'b1;
      idle(5);
      reg_rd(ST_ADDR, 8'h00, "R3 no capture when disabled");
      check_irq(1'b0, "R3 irq stays low");
      gpio_in[1] = 1'b0;

      // R6 rising edge on a masked pin
      reg_wr(AW'(2), 8'h06);
      gpio_in[2] = 1'b1;
      idle(4);
      gpio_in[2] = 1'b0;
      idle(4);
      reg_rd(ST_ADDR, 8'h04, "R6 edge captured while masked");
      check_irq(1'b0, "R7 masked pin keeps irq low");
      reg_wr(AW'(2), 8'h0E);
      idle(1);
      check_irq(1'b1, "R7 irq after report enable set");
      reg_wr(ST_ADDR, 8'h04);
      idle(2);
      reg_rd(ST_ADDR, 8'h00, "R8 edge bit cleared");

      // R6 held level after an edge does not recapture
      gpio_in[2] = 1'b1;
      idle(4);
      reg_wr(ST_ADDR, 8'h04);
      idle(2);
      reg_rd(ST_ADDR, 8'h00, "R6 edge not recaptured while held");
      gpio_in[2] = 1'b0;
      idle(4);

      // R6 falling edge mode ignores rising transitions
      reg_wr(AW'(4), 8'h07);
      gpio_in[4] = 1'b1;
      idle(4);
      reg_rd(ST_ADDR, 8'h00, "R6 falling mode ignores rise");
      gpio_in[4] = 1'b0;
      idle(4);
      reg_rd(ST_ADDR, 8'h10, "R6 falling edge captured");

      // R8 clearing one bit leaves others: set pin2 as well
      gpio_in[2] = 1'b1;
      idle(4);
      reg_wr(ST_ADDR, 8'h10);
      idle(1);
      reg_rd(ST_ADDR, 8'h04, "R8 selective clear");
      reg_wr(ST_ADDR, 8'h04);
      gpio_in[2] = 1'b0;

      // R9 setting changes on a steady high input
      gpio_in[6] = 1'b1;
      idle(4);
      reg_wr(AW'(6), 8'h06);
      idle(4);
      reg_rd(ST_ADDR, 8'h00, "R9 no event entering rising mode");
      reg_wr(AW'(6), 8'h07);
      idle(4);
      reg_rd(ST_ADDR, 8'h00, "R9 no event entering falling mode");
      gpio_in[6] = 1'b0;
      idle(4);
      reg_rd(ST_ADDR, 8'h40, "R9 real edge still seen");
      reg_wr(ST_ADDR, 8'h40);

      // R2 level-low polarity
      reg_wr(AW'(7), 8'h05);
      idle(3);
      reg_rd(ST_ADDR, 8'h80, "R2 level-low captures low input");
      gpio_in[7] = 1'b1;
      idle(4);
      reg_wr(ST_ADDR, 8'h80);
      idle(2);
      reg_rd(ST_ADDR, 8'h00, "R2 level-low idle when high");

      idle(3);
      finish_run();
   end

endmodule